// File: doc/BRIEF.md
# Two-Channel Serial Audio Port

This block is a full-duplex serial audio port for a four-wire bus: bit clock, frame sync, serial data in and serial data out. It carries two voice channels. Each channel occupies a slot inside the frame. The slot starts a programmable number of bit clocks after the frame sync edge, and its bit count is also programmable. The two slots are configured independently, so the port can match PCM codecs with long or short frame sync as well as I2S-style left/right layouts.

The port can run as bus master, where it divides the system clock down to the bit clock and generates the frame sync. It can also run as a slave, where both signals come from outside and are brought into the system clock domain through two-flop synchronisers. Host logic exchanges parallel samples with the port through valid/ready handshakes. Each channel has its own transmit holding register and its own receive register. The serial data output is enabled only while a channel slot is being shifted out, so other devices can drive the line at all other times.

Top module: `pcm_audio_port`

## Requirements
- R1: With `cfg_master`=1 the bit clock toggles every `cfg_half_div`+1 system clocks, so one bit clock period is 2*(`cfg_half_div`+1) clocks. Each frame is `cfg_frame_len` bit clocks long. The frame sync rises together with the bit clock at the start of the frame and stays high for `cfg_fs_width` bit clocks (1 gives a short pulse, more gives a long pulse). `bclk_oe` and `fsync_oe` equal `cfg_master`.
- R2: With `cfg_master`=0 the port takes its timing from `bclk_in` and `fsync_in`. `bclk_out` stays low and both clock/sync output enables are low.
- R3: Bit period 0 is the bit clock in which frame sync is first seen high at a falling edge. Channel c occupies bit periods `cfg_slot_off[c]` to `cfg_slot_off[c]`+`cfg_slot_len[c]`-1. The offset must be at least 1 and the length must be 8 to SW (40). If the two slots overlap, channel 0 wins.
- R4: `sd_oe` is high only during bit periods that belong to a slot, and never before the first frame. While `sd_oe` is low, `sd_out` is 0.
- R5: `sd_out` and `sd_oe` change only on bit-clock rising edges. `sd_in` is sampled on bit-clock falling edges. The bit clock half period must be at least 4 system clocks.
- R6: When `cfg_lsb_first`=0, sample bit len-1 goes first on the wire. When `cfg_lsb_first`=1, bit 0 goes first. The same order applies to transmit and receive.
- R7: A sample offered on `tx_data[c]` is accepted when `tx_valid[c]` and `tx_ready[c]` are both high. `tx_ready[c]` is low from acceptance until the sample moves into the shifter at the first bit of the channel's slot.
- R8: If the holding register is empty at a slot start, the port sends the previous sample again and sets `underrun[c]`. The flag stays set until reset.
- R9: After the last bit of a slot, `rx_data[c]` holds the received sample with zeros above its length and `rx_valid[c]` goes high. `rx_valid[c]` stays high until `rx_ready[c]` is seen.
- R10: Offsets, lengths and bit order are captured at each frame start. Frame length and sync width are captured at each master frame wrap. A change made in mid-frame first affects the next frame.
- R11: After reset `sd_oe`=0, `rx_valid`=0, `underrun`=0 and `tx_ready`=11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = generate bit clock and frame sync |
| cfg_half_div | input | DW | Bit clock half period minus one, in system clocks |
| cfg_frame_len | input | CW | Bit clocks per frame (master) |
| cfg_fs_width | input | CW | Frame sync high time in bit clocks (master) |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_slot_off | input | 2xCW | Per-channel slot start, in bit clocks after sync |
| cfg_slot_len | input | 2xCW | Per-channel sample length in bits |
| bclk_in | input | 1 | External bit clock (slave) |
| fsync_in | input | 1 | External frame sync (slave) |
| bclk_out | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Pad enable for bit clock |
| fsync_out | output | 1 | Generated frame sync |
| fsync_oe | output | 1 | Pad enable for frame sync |
| sd_in | input | 1 | Serial data in |
| sd_out | output | 1 | Serial data out |
| sd_oe | output | 1 | Pad enable for serial data out |
| tx_data | input | 2xSW | Transmit samples per channel |
| tx_valid | input | 2 | Transmit sample offered |
| tx_ready | output | 2 | Holding register empty |
| rx_data | output | 2xSW | Received samples per channel |
| rx_valid | output | 2 | Received sample available |
| rx_ready | input | 2 | Host takes received sample |
| underrun | output | 2 | Sticky repeat-sample flag |

## Verification
Some properties are checked on every cycle by the assertions. Serial data and its enable move only after a bit-clock rising edge, and the output stays off before lock. A generated frame sync changes only with a bit-clock rise. Underrun flags never clear, the holding register refuses data once it is full, and a pending received sample is not dropped without `rx_ready`. The bench scenarios cover what a cycle rule cannot show: the slot layout on the wire, the bit order, loopback of samples through the receiver, frame and sync timing in both modes, repetition of the last sample on underrun, and configuration changes taking effect only at the next frame.

// File: rtl/pcm_audio_port.sv
module pcm_audio_port #(
  parameter int SW = 40,
  parameter int CW = 8,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_master,
  input  logic [DW-1:0]        cfg_half_div,
  input  logic [CW-1:0]        cfg_frame_len,
  input  logic [CW-1:0]        cfg_fs_width,
  input  logic                 cfg_lsb_first,
  input  logic [1:0][CW-1:0]   cfg_slot_off,
  input  logic [1:0][CW-1:0]   cfg_slot_len,
  input  logic                 bclk_in,
  input  logic                 fsync_in,
  output logic                 bclk_out,
  output logic                 bclk_oe,
  output logic                 fsync_out,
  output logic                 fsync_oe,
  input  logic                 sd_in,
  output logic                 sd_out,
  output logic                 sd_oe,
  input  logic [1:0][SW-1:0]   tx_data,
  input  logic [1:0]           tx_valid,
  output logic [1:0]           tx_ready,
  output logic [1:0][SW-1:0]   rx_data,
  output logic [1:0]           rx_valid,
  input  logic [1:0]           rx_ready,
  output logic [1:0]           underrun
);
  localparam int IW = $clog2(SW);

  logic [1:0] bclk_sy, fs_sy, sd_sy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bclk_sy <= '0;
      fs_sy   <= '0;
      sd_sy   <= '0;
    end else begin
      bclk_sy <= {bclk_sy[0], bclk_in};
      fs_sy   <= {fs_sy[0], fsync_in};
      sd_sy   <= {sd_sy[0], sd_in};
    end

  // master timing generator
  logic [DW-1:0] div_cnt;
  logic          sck_r, fs_r;
  logic [CW-1:0] mcnt, m_flen, m_fsw;
  logic [CW:0]   mnext;
  logic          mwrap;

  assign mnext = {1'b0, mcnt} + (CW+1)'(1);
  assign mwrap = mnext >= {1'b0, m_flen};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_cnt <= '0;
      sck_r   <= 1'b0;
      fs_r    <= 1'b0;
      mcnt    <= '1;
      m_flen  <= '0;
      m_fsw   <= '0;
    end else if (!cfg_master) begin
      div_cnt <= '0;
      sck_r   <= 1'b0;
      fs_r    <= 1'b0;
      mcnt    <= '1;
    end else if (div_cnt >= cfg_half_div) begin
      div_cnt <= '0;
      sck_r   <= ~sck_r;
      if (!sck_r) begin
        if (mwrap) begin
          mcnt   <= '0;
          fs_r   <= 1'b1;
          m_flen <= cfg_frame_len;
          m_fsw  <= cfg_fs_width;
        end else begin
          mcnt <= mnext[CW-1:0];
          fs_r <= mnext < {1'b0, m_fsw};
        end
      end
    end else begin
      div_cnt <= div_cnt + DW'(1);
    end

  assign bclk_out  = sck_r;
  assign fsync_out = fs_r;
  assign bclk_oe   = cfg_master;
  assign fsync_oe  = cfg_master;

  // common edge detection
  logic sck_i, fs_i, sck_q, rise, fall;
  assign sck_i = cfg_master ? sck_r : bclk_sy[1];
  assign fs_i  = cfg_master ? fs_r  : fs_sy[1];
  assign rise  = sck_i & ~sck_q;
  assign fall  = ~sck_i & sck_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_i;

  // frame position tracking and configuration shadow
  logic              fs_q, locked, fstart, s_lsb;
  logic [CW-1:0]     cnt, cnt_inc, cur, nxt;
  logic [1:0][CW-1:0] s_off, s_len;

  assign cnt_inc = (&cnt) ? cnt : cnt + CW'(1);
  assign fstart  = fall & fs_i & ~fs_q;
  assign cur     = fstart ? '0 : cnt_inc;
  assign nxt     = cnt_inc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fs_q   <= 1'b0;
      locked <= 1'b0;
      cnt    <= '1;
      s_off  <= '0;
      s_len  <= '0;
      s_lsb  <= 1'b0;
    end else if (fall) begin
      fs_q <= fs_i;
      cnt  <= cur;
      if (fstart) begin
        locked <= 1'b1;
        s_off  <= cfg_slot_off;
        s_len  <= cfg_slot_len;
        s_lsb  <= cfg_lsb_first;
      end
    end

  // serial output stage
  logic [1:0] t_win, t_bit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sd_out <= 1'b0;
      sd_oe  <= 1'b0;
    end else if (rise) begin
      sd_oe  <= |t_win;
      sd_out <= t_win[0] ? t_bit[0] : (t_win[1] & t_bit[1]);
    end

  p_launch_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rise) |-> $stable(sd_out) && $stable(sd_oe));
  p_quiet_unlocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !sd_oe);
  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_oe |-> !sd_out);
  p_sync_on_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && $past(cfg_master) && !$stable(fs_r) |-> $rose(sck_r));
  p_slave_clock_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |=> !bclk_out);

  // per-channel slot engines
  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [CW:0]   endp;
    logic [CW-1:0] kt, kr, it, ir;
    logic          in_t, in_r, load, done, full, und, rvalid;
    logic [SW-1:0] hold, smp, src, rsh, rnxt, rdata;

    assign endp = {1'b0, s_off[c]} + {1'b0, s_len[c]};
    assign kt   = nxt - s_off[c];
    assign kr   = cur - s_off[c];
    assign it   = s_lsb ? kt : s_len[c] - CW'(1) - kt;
    assign ir   = s_lsb ? kr : s_len[c] - CW'(1) - kr;
    assign in_t = locked && (nxt >= s_off[c]) && ({1'b0, nxt} < endp);
    assign in_r = locked && (cur >= s_off[c]) && ({1'b0, cur} < endp);
    assign load = rise && in_t && (kt == '0);
    assign done = fall && in_r && (kr == s_len[c] - CW'(1));
    assign src  = (kt == '0 && full) ? hold : smp;

    assign t_win[c]    = in_t;
    assign t_bit[c]    = src[it[IW-1:0]];
    assign tx_ready[c] = ~full;
    assign underrun[c] = und;
    assign rx_valid[c] = rvalid;
    assign rx_data[c]  = rdata;

    always_comb begin
      rnxt = (kr == '0) ? '0 : rsh;
      rnxt[ir[IW-1:0]] = sd_sy[1];
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        hold <= '0;
        smp  <= '0;
        full <= 1'b0;
        und  <= 1'b0;
      end else begin
        if (load) begin
          if (full) begin
            smp  <= hold;
            full <= 1'b0;
          end else begin
            und <= 1'b1;
          end
        end
        if (tx_valid[c] && !full) begin
          hold <= tx_data[c];
          full <= 1'b1;
        end
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        rsh    <= '0;
        rdata  <= '0;
        rvalid <= 1'b0;
      end else begin
        if (fall && in_r) rsh <= rnxt;
        if (done) begin
          rdata  <= rnxt;
          rvalid <= 1'b1;
        end else if (rx_ready[c]) begin
          rvalid <= 1'b0;
        end
      end

    p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      underrun[c] |=> underrun[c]);
    p_full_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid[c] && tx_ready[c] |=> !tx_ready[c]);
    p_rx_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid[c] && !rx_ready[c] |=> rx_valid[c]);
  end

endmodule

// File: tb/pcm_audio_port_tb.sv
module pcm_audio_port_tb;
  localparam int SW = 40;
  localparam int CW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                cfg_master = 1'b1;
  logic [DW-1:0]       cfg_half_div = 16'd3;
  logic [CW-1:0]       cfg_frame_len = 8'd32;
  logic [CW-1:0]       cfg_fs_width = 8'd1;
  logic                cfg_lsb_first = 1'b0;
  logic [1:0][CW-1:0]  cfg_slot_off;
  logic [1:0][CW-1:0]  cfg_slot_len;
  logic                bclk_in = 1'b0, fsync_in = 1'b0;
  logic                bclk_out, bclk_oe, fsync_out, fsync_oe;
  logic                sd_in, sd_out, sd_oe;
  logic [1:0][SW-1:0]  tx_data = '0;
  logic [1:0]          tx_valid = '0, tx_ready;
  logic [1:0][SW-1:0]  rx_data;
  logic [1:0]          rx_valid, underrun;
  logic [1:0]          rx_ready = '0;

  assign sd_in = sd_oe ? sd_out : 1'b0;

  pcm_audio_port #(.SW(SW), .CW(CW), .DW(DW)) u_dut (
    .clk, .rst_n, .cfg_master, .cfg_half_div, .cfg_frame_len, .cfg_fs_width,
    .cfg_lsb_first, .cfg_slot_off, .cfg_slot_len, .bclk_in, .fsync_in,
    .bclk_out, .bclk_oe, .fsync_out, .fsync_oe, .sd_in, .sd_out, .sd_oe,
    .tx_data, .tx_valid, .tx_ready, .rx_data, .rx_valid, .rx_ready, .underrun);

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      errors++;
      finish_run();
    end
  end

  // wire monitor: records one frame at bit-clock falling edges
  logic cu_oe [64], cu_sd [64], cu_fs [64];
  logic lo_oe [64], lo_sd [64], lo_fs [64];
  int mon_frames = 0, mon_idx = 0, mon_len = 0, mon_span = 0, mon_t0 = 0;
  bit mon_go = 0, mon_sck_q = 0, mon_fs_q = 0;

  initial forever begin
    @(posedge clk);
    #1;
    begin
      logic s, f;
      s = cfg_master ? bclk_out : bclk_in;
      f = cfg_master ? fsync_out : fsync_in;
      if (mon_sck_q && !s) begin
        if (f && !mon_fs_q) begin
          if (mon_go) begin
            lo_oe = cu_oe; lo_sd = cu_sd; lo_fs = cu_fs;
            mon_len = mon_idx + 1;
            mon_span = cyc - mon_t0;
            mon_frames++;
          end
          mon_t0 = cyc;
          mon_idx = 0;
          mon_go = 1;
          for (int i = 0; i < 64; i++) begin
            cu_oe[i] = 0; cu_sd[i] = 0; cu_fs[i] = 0;
          end
        end else begin
          mon_idx++;
        end
        mon_fs_q = f;
        if (mon_idx < 64) begin
          cu_oe[mon_idx] = sd_oe; cu_sd[mon_idx] = sd_out; cu_fs[mon_idx] = f;
        end
      end
      mon_sck_q = s;
    end
  end

  // slave-mode bus master model
  bit slave_run = 0;
  initial forever begin
    @(negedge clk);
    if (slave_run) begin
      for (int i = 0; i < 32; i++) begin
        bclk_in = 1'b1;
        fsync_in = (i < 16);
        repeat (8) @(negedge clk);
        bclk_in = 1'b0;
        repeat (8) @(negedge clk);
      end
    end
  end

  function automatic logic [SW-1:0] msk(logic [SW-1:0] v, int len);
    logic [SW-1:0] r = '0;
    for (int k = 0; k < len; k++) r[k] = v[k];
    return r;
  endfunction

  function automatic logic [SW-1:0] pick(int off, int len, bit lsb);
    logic [SW-1:0] v = '0;
    for (int k = 0; k < len; k++) begin
      if (lsb) v[k] = lo_sd[off + k];
      else     v[len - 1 - k] = lo_sd[off + k];
    end
    return v;
  endfunction

  function automatic int oe_errs(int o0, int l0, int o1, int l1, int fl);
    int n = 0;
    for (int i = 0; i < fl; i++) begin
      logic e;
      e = (i >= o0 && i < o0 + l0) || (i >= o1 && i < o1 + l1);
      if (lo_oe[i] !== e) n++;
    end
    return n;
  endfunction

  function automatic int fs_count(int fl);
    int n = 0;
    for (int i = 0; i < fl; i++) if (lo_fs[i]) n++;
    return n;
  endfunction

  task automatic push(int c, logic [SW-1:0] v);
    @(negedge clk);
    while (!tx_ready[c]) @(negedge clk);
    tx_data[c] = v;
    tx_valid[c] = 1'b1;
    @(negedge clk);
    tx_valid[c] = 1'b0;
  endtask

  task automatic wait_frames(int k);
    int target = mon_frames + k;
    while (mon_frames < target) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_mid();
    while (mon_idx != 20) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(bit master);
    @(negedge clk);
    rst_n = 1'b0;
    slave_run = 0;
    cfg_master = master;
    cfg_lsb_first = 1'b0;
    cfg_slot_off[0] = 8'd1;  cfg_slot_len[0] = 8'd16;
    cfg_slot_off[1] = 8'd17; cfg_slot_len[1] = 8'd12;
    mon_go = 0; mon_frames = 0; mon_idx = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  localparam logic [SW-1:0] A0 = 40'hAB_CDEF_1234, B0 = 40'h55_0000_0A5C;
  localparam logic [SW-1:0] A1 = 40'h00_0000_B00D, B1 = 40'h12_3456_78C3;
  localparam logic [SW-1:0] A2 = 40'hFF_FFFF_6E91, B2 = 40'h00_0000_0DB7;

  task automatic t_reset();
    do_reset(1'b1);
    #1;
    chk(sd_oe == 1'b0, "R11 sd_oe", sd_oe, 0);
    chk(tx_ready == 2'b11 && rx_valid == 2'b00 && underrun == 2'b00,
        "R11 handshake/flags", {tx_ready, rx_valid, underrun}, 6'b110000);
    chk(bclk_oe && fsync_oe, "R1 master pad enables", {bclk_oe, fsync_oe}, 2'b11);
  endtask

  task automatic t_master_basic();
    push(0, A0);
    push(1, B0);
    chk(tx_ready == 2'b00, "R7 ready low while held", tx_ready, 0);
    wait_frames(1);
    chk(mon_len == 32 && mon_span == 32 * 8, "R1 frame length and bit clock period",
        {mon_len, mon_span}, {32'd32, 32'd256});
    chk(fs_count(32) == 1, "R1 short frame sync width", fs_count(32), 1);
    chk(pick(1, 16, 0) == msk(A0, 16), "R3 R6 ch0 slot msb-first", pick(1, 16, 0), msk(A0, 16));
    chk(pick(17, 12, 0) == msk(B0, 12), "R3 ch1 slot", pick(17, 12, 0), msk(B0, 12));
    chk(oe_errs(1, 16, 17, 12, 32) == 0, "R4 output enable window", oe_errs(1, 16, 17, 12, 32), 0);
    chk(rx_valid == 2'b11 && rx_data[0] == msk(A0, 16) && rx_data[1] == msk(B0, 12),
        "R5 R9 loopback receive", rx_data[0], msk(A0, 16));
    chk(tx_ready == 2'b11 && underrun == 2'b00, "R7 R8 refilled in time", {tx_ready, underrun}, 4'b1100);
    repeat (3) @(negedge clk);
    chk(rx_valid == 2'b11, "R9 valid held without ready", rx_valid, 2'b11);
    rx_ready = 2'b11;
    @(negedge clk);
    rx_ready = 2'b00;
    chk(rx_valid == 2'b00, "R9 valid cleared by ready", rx_valid, 0);
  endtask

  task automatic t_underrun();
    wait_frames(1);
    chk(pick(1, 16, 0) == msk(A0, 16) && pick(17, 12, 0) == msk(B0, 12),
        "R8 last sample repeated", pick(1, 16, 0), msk(A0, 16));
    chk(underrun == 2'b11, "R8 underrun flags set", underrun, 2'b11);
  endtask

  task automatic t_cfg_boundary();
    wait_mid();
    cfg_lsb_first = 1'b1;
    cfg_slot_off[1] = 8'd20;
    cfg_slot_len[1] = 8'd8;
    push(0, A1);
    push(1, B1);
    chk(tx_ready == 2'b00, "R7 held until next slot", tx_ready, 0);
    wait_frames(1);
    chk(oe_errs(1, 16, 17, 12, 32) == 0 && pick(17, 12, 0) == msk(B0, 12),
        "R10 running frame keeps old layout", pick(17, 12, 0), msk(B0, 12));
    wait_frames(1);
    chk(oe_errs(1, 16, 20, 8, 32) == 0, "R10 R3 new layout next frame", oe_errs(1, 16, 20, 8, 32), 0);
    chk(pick(1, 16, 1) == msk(A1, 16) && pick(20, 8, 1) == msk(B1, 8),
        "R6 lsb-first transmit", pick(20, 8, 1), msk(B1, 8));
    chk(rx_data[0] == msk(A1, 16) && rx_data[1] == msk(B1, 8),
        "R6 R9 lsb-first receive", rx_data[1], msk(B1, 8));
    chk(underrun == 2'b11, "R8 flag stays after refill", underrun, 2'b11);
  endtask

  task automatic t_divider();
    wait_mid();
    cfg_half_div = 16'd4;
    wait_frames(2);
    chk(mon_span == 32 * 10, "R1 bit clock follows divider", mon_span, 320);
  endtask

  task automatic t_slave();
    do_reset(1'b0);
    slave_run = 1;
    push(0, A2);
    push(1, B2);
    wait_frames(1);
    chk(!bclk_oe && !fsync_oe && !bclk_out, "R2 slave leaves clock pins",
        {bclk_oe, fsync_oe, bclk_out}, 0);
    chk(pick(1, 16, 0) == msk(A2, 16) && pick(17, 12, 0) == msk(B2, 12),
        "R2 R3 slave transmit slots", pick(1, 16, 0), msk(A2, 16));
    chk(oe_errs(1, 16, 17, 12, 32) == 0, "R2 R4 slave enable window (long sync)",
        oe_errs(1, 16, 17, 12, 32), 0);
    chk(rx_data[0] == msk(A2, 16) && rx_data[1] == msk(B2, 12) && rx_valid == 2'b11,
        "R2 R5 slave receive", rx_data[1], msk(B2, 12));
  endtask

  initial begin
    cfg_slot_off[0] = 8'd1;  cfg_slot_len[0] = 8'd16;
    cfg_slot_off[1] = 8'd17; cfg_slot_len[1] = 8'd12;
    t_reset();
    t_master_basic();
    t_underrun();
    t_cfg_boundary();
    t_divider();
    t_slave();
    finish_run();
  end
endmodule